// File: doc/BRIEF.md
# Translation Lookaside Buffer

This block is a small fully associative translation cache for a segmented-paging memory system. A virtual page is named by a key made of a segment number followed by a page index inside that segment. Each cached entry binds such a key to a physical frame number and to two permission flags, one for reading and one for writing. Any lookup key is compared against every stored key at once. The hit flag, the frame and the permissions come back combinationally in the same cycle.

Software handles misses. After it walks the tables, it installs the translation through the fill port. If the key is already cached, the fill rewrites that entry. Otherwise the fill takes the lowest-numbered empty slot. When every slot is occupied, a rotating victim pointer chooses the slot to overwrite. A single flush pulse empties the whole buffer on one clock edge, which is what a context switch needs. A flush always overrides a fill in the same cycle.

Top module: `xlate_cache`

## Requirements
- R1: After reset no entry is valid, so every lookup misses until a fill has been done.
- R2: A lookup whose key {segment, page} (segment in the upper bits) matches a valid entry asserts hit in the same cycle and returns that entry's frame, read flag and write flag.
- R3: On a miss, the hit, frame, read and write outputs are all zero.
- R4: Keys that share a page index but differ in segment are separate translations and do not alias.
- R5: A fill whose key is not cached, made while an empty slot exists, goes into the lowest-numbered empty slot.
- R6: A fill whose key is already cached rewrites that entry in place. No second copy of the key is created and no other entry changes.
- R7: A fill of a new key into a full buffer overwrites the slot named by a round-robin pointer. The pointer is 0 after reset or flush, advances by one after each such overwrite, and wraps from the last slot to 0.
- R8: A flush invalidates every entry at the next clock edge, so every lookup in the following cycle misses.
- R9: When flush and fill are both asserted in one cycle, the flush wins and the filled key is not cached afterwards.
- R10: A fill takes effect at the clock edge. A lookup of the same key during the fill cycle still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_seg | input | SEG_W | Lookup segment number |
| lk_page | input | PAGE_W | Lookup page index |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_frame | output | FRAME_W | Frame of the matching entry, zero on a miss |
| lk_rd | output | 1 | Read permission of the matching entry |
| lk_wr | output | 1 | Write permission of the matching entry |
| fill_en | input | 1 | Install a translation on this edge |
| fill_seg | input | SEG_W | Segment number to install |
| fill_page | input | PAGE_W | Page index to install |
| fill_frame | input | FRAME_W | Frame number to install |
| fill_rd | input | 1 | Read permission to install |
| fill_wr | input | 1 | Write permission to install |
| flush | input | 1 | Invalidate all entries on this edge |

## Verification
A bad valid bit or a bad stored key shows on the lookup port as soon as that key is presented: a false hit, a false miss, or a wrong frame in the same cycle. A wrong victim choice or a drifting round-robin pointer stays hidden until the buffer is full. It then shows up one fill later, when the wrong key disappears. The reference model therefore runs long streams of fills over a small key range, so that the buffer is forced into repeated overwrites and flushes. It compares the lookup port against the model on every cycle, which catches such a divergence within a few cycles of the first overwrite that goes wrong.

// File: rtl/xlate_cache_pkg.sv
package xlate_cache_pkg;

  // What a fill request does to the entry array on the next edge.
  typedef enum logic [1:0] {
    FILL_IDLE   = 2'd0,
    FILL_UPDATE = 2'd1,
    FILL_FREE   = 2'd2,
    FILL_EVICT  = 2'd3
  } fill_kind_e;

endpackage

// File: rtl/xc_first.sv
// Lowest-index selector over a request vector.
module xc_first #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);

  always_comb begin
    found = |req;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/xc_slot.sv
// One buffer entry: valid flag, key and payload, with two comparators.
module xc_slot #(
  parameter int KEY_W = 6,
  parameter int PAY_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             we,
  input  logic [KEY_W-1:0] wkey,
  input  logic [PAY_W-1:0] wpay,
  input  logic [KEY_W-1:0] lkey,
  input  logic [KEY_W-1:0] ckey,
  output logic             vld,
  output logic             lk_eq,
  output logic             ck_eq,
  output logic [PAY_W-1:0] pay
);

  logic             vld_q, vld_d;
  logic [KEY_W-1:0] key_q, key_d;
  logic [PAY_W-1:0] pay_q, pay_d;
  logic             load;

  assign load = clr | we;

  always_comb begin
    vld_d = vld_q;
    key_d = key_q;
    pay_d = pay_q;
    if (clr) begin
      vld_d = 1'b0;
    end else if (we) begin
      vld_d = 1'b1;
      key_d = wkey;
      pay_d = wpay;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      key_q <= '0;
      pay_q <= '0;
    end else if (load) begin
      vld_q <= vld_d;
      key_q <= key_d;
      pay_q <= pay_d;
    end
  end

  assign vld   = vld_q;
  assign lk_eq = vld_q && (key_q == lkey);
  assign ck_eq = vld_q && (key_q == ckey);
  assign pay   = pay_q;

endmodule

// File: rtl/xc_rr.sv
// Rotating victim pointer used once the buffer is full.
module xc_rr #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  output logic [IW-1:0] ptr
);

  localparam logic [IW-1:0] LAST = IW'(N - 1);

  logic [IW-1:0] ptr_q, ptr_d;
  logic          en;

  assign en = clr | step;

  always_comb begin
    ptr_d = ptr_q;
    if (clr)                ptr_d = '0;
    else if (step) begin
      if (ptr_q == LAST)    ptr_d = '0;
      else                  ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ptr_q <= '0;
    else if (en) ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/xlate_cache.sv
module xlate_cache
  import xlate_cache_pkg::*;
#(
  parameter int SEG_W   = 3,
  parameter int PAGE_W  = 3,
  parameter int FRAME_W = 3,
  parameter int DEPTH   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SEG_W-1:0]   lk_seg,
  input  logic [PAGE_W-1:0]  lk_page,
  output logic               lk_hit,
  output logic [FRAME_W-1:0] lk_frame,
  output logic               lk_rd,
  output logic               lk_wr,
  input  logic               fill_en,
  input  logic [SEG_W-1:0]   fill_seg,
  input  logic [PAGE_W-1:0]  fill_page,
  input  logic [FRAME_W-1:0] fill_frame,
  input  logic               fill_rd,
  input  logic               fill_wr,
  input  logic               flush
);

  localparam int KEY_W = SEG_W + PAGE_W;
  localparam int PAY_W = FRAME_W + 2;
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [KEY_W-1:0] lk_key_w, fill_key_w;
  logic [PAY_W-1:0] fill_pay;
  logic [DEPTH-1:0] vld_vec, lk_match, fill_match, wsel;
  logic [PAY_W-1:0] pay_arr [DEPTH];

  logic             upd_any, free_any;
  logic [IW-1:0]    upd_idx, free_idx, lk_idx, rr_ptr, wr_idx;
  fill_kind_e       kind;
  logic [PAY_W-1:0] lk_pay;

  assign lk_key_w   = {lk_seg, lk_page};
  assign fill_key_w = {fill_seg, fill_page};
  assign fill_pay   = {fill_rd, fill_wr, fill_frame};

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    xc_slot #(.KEY_W(KEY_W), .PAY_W(PAY_W)) u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (flush),
      .we    (wsel[g]),
      .wkey  (fill_key_w),
      .wpay  (fill_pay),
      .lkey  (lk_key_w),
      .ckey  (fill_key_w),
      .vld   (vld_vec[g]),
      .lk_eq (lk_match[g]),
      .ck_eq (fill_match[g]),
      .pay   (pay_arr[g])
    );
  end

  xc_first #(.N(DEPTH), .IW(IW)) u_upd_sel (
    .req (fill_match), .found (upd_any), .idx (upd_idx)
  );

  xc_first #(.N(DEPTH), .IW(IW)) u_free_sel (
    .req (~vld_vec), .found (free_any), .idx (free_idx)
  );

  xc_first #(.N(DEPTH), .IW(IW)) u_lk_sel (
    .req (lk_match), .found (lk_hit), .idx (lk_idx)
  );

  xc_rr #(.N(DEPTH), .IW(IW)) u_rr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (flush),
    .step  (kind == FILL_EVICT),
    .ptr   (rr_ptr)
  );

  // Fill decision: flush first, then in-place update, then free slot, then victim.
  always_comb begin
    kind   = FILL_IDLE;
    wr_idx = '0;
    if (fill_en && !flush) begin
      if (upd_any) begin
        kind   = FILL_UPDATE;
        wr_idx = upd_idx;
      end else if (free_any) begin
        kind   = FILL_FREE;
        wr_idx = free_idx;
      end else begin
        kind   = FILL_EVICT;
        wr_idx = rr_ptr;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      wsel[i] = (kind != FILL_IDLE) && (wr_idx == IW'(i));
    end
  end

  assign lk_pay   = lk_hit ? pay_arr[lk_idx] : '0;
  assign lk_rd    = lk_pay[PAY_W-1];
  assign lk_wr    = lk_pay[PAY_W-2];
  assign lk_frame = lk_pay[FRAME_W-1:0];

endmodule

// File: rtl/xlate_cache_chk.sv
module xlate_cache_chk #(
  parameter int KEY_W   = 6,
  parameter int FRAME_W = 3,
  parameter int DEPTH   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush,
  input logic               fill_en,
  input logic [KEY_W-1:0]   fill_key,
  input logic [FRAME_W-1:0] fill_frame,
  input logic               fill_rd,
  input logic               fill_wr,
  input logic [KEY_W-1:0]   lk_key,
  input logic               lk_hit,
  input logic [FRAME_W-1:0] lk_frame,
  input logic               lk_rd,
  input logic               lk_wr,
  input logic [DEPTH-1:0]   vld,
  input logic [DEPTH-1:0]   lk_match
);

  // R1: a hit needs at least one valid entry
  assert_hit_needs_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (vld != '0));

  // R3: a miss drives quiet outputs
  assert_miss_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_frame == '0 && !lk_rd && !lk_wr));

  // R2: a filled key is visible with its payload in the next cycle
  assert_fill_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !flush) |=> ((lk_key != $past(fill_key)) ||
      (lk_hit && lk_frame == $past(fill_frame) &&
       lk_rd == $past(fill_rd) && lk_wr == $past(fill_wr))));

  // R6: keys stay unique
  assert_unique_keys_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));

  // R8: nothing hits right after a flush
  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lk_hit);

  // R9: a fill beside a flush leaves nothing valid
  assert_flush_beats_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld == '0));

  // R7: a full buffer stays full without a flush
  assert_full_stays_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((&vld) && !flush) |=> (&vld));

endmodule

bind xlate_cache xlate_cache_chk #(
  .KEY_W   (SEG_W + PAGE_W),
  .FRAME_W (FRAME_W),
  .DEPTH   (DEPTH)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush      (flush),
  .fill_en    (fill_en),
  .fill_key   (fill_key_w),
  .fill_frame (fill_frame),
  .fill_rd    (fill_rd),
  .fill_wr    (fill_wr),
  .lk_key     (lk_key_w),
  .lk_hit     (lk_hit),
  .lk_frame   (lk_frame),
  .lk_rd      (lk_rd),
  .lk_wr      (lk_wr),
  .vld        (vld_vec),
  .lk_match   (lk_match)
);

// File: tb/sim_xlate_cache.sv
`timescale 1ns/1ps
module sim_xlate_cache;

  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] lk_seg, lk_page, fill_seg, fill_page, fill_frame;
  logic       lk_hit, lk_rd, lk_wr, fill_en, fill_rd, fill_wr, flush;
  logic [2:0] lk_frame;

  int checks = 0;
  int fails  = 0;

  // behavioural reference state
  bit m_v  [N];
  int m_k  [N];
  int m_f  [N];
  bit m_r  [N];
  bit m_w  [N];
  int m_rr;

  always #4 clk = ~clk;

  xlate_cache u0 (
    .clk(clk), .rst_n(rst_n),
    .lk_seg(lk_seg), .lk_page(lk_page),
    .lk_hit(lk_hit), .lk_frame(lk_frame), .lk_rd(lk_rd), .lk_wr(lk_wr),
    .fill_en(fill_en), .fill_seg(fill_seg), .fill_page(fill_page),
    .fill_frame(fill_frame), .fill_rd(fill_rd), .fill_wr(fill_wr),
    .flush(flush)
  );

  function automatic int find_key(int k);
    for (int i = 0; i < N; i++) if (m_v[i] && m_k[i] == k) return i;
    return -1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_k[i] = 0; m_f[i] = 0; m_r[i] = 0; m_w[i] = 0;
    end
    m_rr = 0;
  endtask

  task automatic model_edge(bit fl, bit fe, int k, int f, bit r, bit w);
    int slot;
    if (fl) begin
      for (int i = 0; i < N; i++) m_v[i] = 0;
      m_rr = 0;
    end else if (fe) begin
      slot = find_key(k);
      if (slot < 0) begin
        for (int i = N - 1; i >= 0; i--) if (!m_v[i]) slot = i;
      end
      if (slot < 0) begin
        slot = m_rr;
        m_rr = (m_rr + 1) % N;
      end
      m_v[slot] = 1; m_k[slot] = k; m_f[slot] = f; m_r[slot] = r; m_w[slot] = w;
    end
  endtask

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, compare lookup, step model at the edge.
  task automatic step(bit fl, bit fe, int fs, int fp, int ff, bit fr, bit fw,
                      int ls, int lp, string tag);
    int  slot;
    bit  eh;
    int  ef;
    bit  er, ew;
    flush = fl; fill_en = fe;
    fill_seg = 3'(fs); fill_page = 3'(fp); fill_frame = 3'(ff);
    fill_rd = fr; fill_wr = fw;
    lk_seg = 3'(ls); lk_page = 3'(lp);
    #1;
    slot = find_key(ls * 8 + lp);
    eh = (slot >= 0);
    ef = eh ? m_f[slot] : 0;
    er = eh ? m_r[slot] : 0;
    ew = eh ? m_w[slot] : 0;
    check(lk_hit === eh && int'(lk_frame) == ef && lk_rd === er && lk_wr === ew,
          tag, "lookup hit/frame/rd/wr",
          {lk_hit, lk_frame, lk_rd, lk_wr}, {eh, 3'(ef), er, ew});
    @(posedge clk);
    model_edge(fl, fe, fs * 8 + fp, ff, fr, fw);
    @(negedge clk);
  endtask

  task automatic probe(int s, int p, string tag);
    step(0, 0, 0, 0, 0, 0, 0, s, p, tag);
  endtask

  task automatic fill(int s, int p, int f, bit r, bit w, string tag);
    step(0, 1, s, p, f, r, w, 0, 0, tag);
  endtask

  initial begin
    #1200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    rst_n = 1'b0;
    flush = 0; fill_en = 0; fill_seg = 0; fill_page = 0; fill_frame = 0;
    fill_rd = 0; fill_wr = 0; lk_seg = 0; lk_page = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R3: empty after reset, quiet outputs
    probe(0, 0, "R1");
    probe(1, 2, "R1");
    probe(7, 7, "R3");
    check(!lk_hit && lk_frame == 0, "R3", "miss outputs", int'(lk_frame), 0);

    // R10: lookup in the fill cycle still misses
    step(0, 1, 1, 2, 5, 1, 0, 1, 2, "R10");
    check(lk_hit === 1'b1, "R10", "hit after edge", lk_hit, 1);
    probe(1, 2, "R2");
    check(lk_frame == 3'd5 && lk_rd && !lk_wr, "R2", "frame", int'(lk_frame), 5);

    // R4: same page, other segment
    probe(2, 2, "R4");
    fill(2, 2, 3, 0, 1, "R4");
    probe(2, 2, "R4");
    probe(1, 2, "R4");

    // R6: rewrite in place
    fill(1, 2, 7, 1, 1, "R6");
    probe(1, 2, "R6");
    check(lk_frame == 3'd7 && lk_wr, "R6", "updated frame", int'(lk_frame), 7);
    probe(2, 2, "R6");

    // R5: fill remaining six slots, then evictions reveal the slot order
    for (int i = 0; i < 6; i++) fill(4, i, i, 1, 0, "R5");
    for (int i = 0; i < 6; i++) probe(4, i, "R5");
    fill(5, 0, 1, 0, 0, "R7");
    probe(1, 2, "R5");
    check(!lk_hit, "R5", "slot 0 victim first", lk_hit, 0);
    probe(2, 2, "R7");
    fill(5, 1, 2, 0, 0, "R7");
    probe(2, 2, "R7");
    check(!lk_hit, "R7", "slot 1 victim second", lk_hit, 0);
    for (int i = 0; i < 10; i++) begin
      fill(6, i % 8, i % 8, i[0], i[1], "R7");
      for (int j = 0; j < 8; j++) probe(4, j, "R7");
    end

    // R8: flush empties everything
    step(1, 0, 0, 0, 0, 0, 0, 6, 1, "R8");
    for (int j = 0; j < 8; j++) probe(6, j, "R8");
    check(!lk_hit, "R8", "after flush", lk_hit, 0);

    // R9: flush beats fill
    fill(3, 3, 4, 1, 1, "R9");
    step(1, 1, 3, 4, 6, 1, 1, 3, 3, "R9");
    probe(3, 4, "R9");
    check(!lk_hit, "R9", "fill under flush", lk_hit, 0);
    probe(3, 3, "R9");

    // mixed stream against the model
    lfsr = 16'hACE1;
    for (int c = 0; c < 3000; c++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[15:9] == 7'd0, lfsr[0] | lfsr[1],
           int'(lfsr[4:2]), int'(lfsr[6:5]), int'(lfsr[9:7]), lfsr[10], lfsr[11],
           int'(lfsr[13:11]), int'(lfsr[3:2]), "R7");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule